// File: doc/BRIEF.md
# Storage Controller Status and Interrupt Unit

This block holds the control and status state of a DMA storage controller and decides when the controller asks the processor for an interrupt. A processor-side port writes and reads three 16-bit registers. Writes may be whole words or single bytes. The registers are a primary control/status register, a secondary unit/error register and a third register that holds parity-check bits and a copy of the interrupt enable. The drive side reports completion, transfer exceptions and attention. The block issues a one-cycle command strobe whenever a GO command is accepted.

There are two paths to an interrupt, and they behave differently. Completion sets an internal request flop on the rising edge of DONE. That flop keeps its value when the enable bit is later cleared. A special condition raises the request only while it, DONE and the enable bit are all true, so clearing the enable drops it at once.

Top module: `dkc_status_irq`

## Requirements
- R1: After reset, the primary register reads 0x0080 (DONE, bit 7, only), the secondary register reads 0x00C0, the third register reads 0x0000, irq_req is low and cmd_go is low.
- R2: A word write, or a low-byte write, of the primary register (wr_sel 0) whose data has bit 7 and bit 6 both set sets the internal request flop, so irq_req rises after that write.
- R3: When DONE goes from 0 to 1 (drv_done or drv_exc), the request flop takes the value that the interrupt enable (primary bit 6) has at that moment. A later write that sets only the enable does not raise irq_req.
- R4: irq_ack, reset and a controller clear each clear the request flop and the interrupt enable. After an acknowledge, bit 6 reads 0 in both the primary and the third register.
- R5: irq_req equals the request flop OR (special condition AND DONE AND enable). Clearing the enable therefore drops a special-condition request, but it does not drop a latched completion request.
- R6: Primary bit 14 (transfer error) reads 1 whenever any error bit in secondary bits 15:8 is set. Primary bit 15 (special condition) reads 1 whenever transfer error is 1 or drv_attn is high. drv_exc sets transfer error and DONE.
- R7: A write that sets bit 14 of the primary register clears transfer error, all secondary error bits and the diagnostic special condition.
- R8: A low-part write of the primary register with GO (bit 0) set and a function code (bits 5:1) of 20 (octal 024) or above, made while DONE is clear, sets program error (secondary bit 10). In that case cmd_go stays low.
- R9: Any other accepted GO pulses cmd_go for one cycle, with cmd_func set to bits 5:1. If the function code is 20 or above, DONE, transfer error and all error flags are also cleared.
- R10: A low-part write of the secondary register with bit 5 set returns every register to its reset state. Secondary bits 7:6 always read 1.
- R11: The primary address-extension bits 9:8 take new data from a high-part write only while DONE is set.
- R12: A secondary write that changes bit 9 (missed transfer) or bit 13 (parity error) from 0 to 1 raises special condition.
- R13: A byte write with wr_hi set applies wr_data[7:0] to bits 15:8 only. A high-byte write of the third register is ignored.
- R14: Third register bits 3:0 can be written and read back. Third register bit 6 mirrors the enable, and writing it sets or clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (bus init) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 primary, 1 secondary, 2 third, 3 none |
| wr_byte | input | 1 | 1 for a byte write, 0 for a word write |
| wr_hi | input | 1 | For byte writes: 1 selects the high byte |
| wr_data | input | 16 | Write data (byte data in bits 7:0) |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 16 | Combinational read data |
| drv_done | input | 1 | Drive pulse: operation complete, sets DONE |
| drv_exc | input | 1 | Drive pulse: transfer exception, sets transfer error and DONE |
| drv_attn | input | 1 | Drive attention level, feeds special condition |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Interrupt request |
| cmd_go | output | 1 | One-cycle strobe for an accepted GO command |
| cmd_func | output | 5 | Function code of the accepted command |

## Verification
Every register, the request flop and cmd_go update on the clock edge that samples a write, a drive pulse or an acknowledge. rd_data and irq_req are combinational from that state. So each result is due one cycle after its stimulus. The only exception is drv_attn, which reaches special condition and irq_req with no register in between. The bench changes inputs on the falling edge and holds them for one full cycle. It releases them on the next falling edge and samples shortly after that. At that point the registered result is stable and the strobe has not yet expired. The cmd_go checks rely on this, since the strobe lasts only one cycle.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

    localparam int DATA_W = 16;
    localparam int FUNC_W = 5;
    localparam int CFG_W  = 5;
    localparam int PCHK_W = 4;
    localparam int UAE_W  = 2;
    localparam int ERR_W  = DATA_W / 2;

    // primary register bit positions
    localparam int B_GO   = 0;
    localparam int B_FLO  = 1;
    localparam int B_FHI  = B_FLO + FUNC_W - 1;
    localparam int B_IE   = 6;
    localparam int B_DONE = 7;
    localparam int B_UAE  = 8;
    localparam int B_TRE  = 14;
    // secondary register positions
    localparam int B_CLR  = 5;
    localparam int B_MXF  = 9;
    localparam int B_PE   = 13;
    // index inside the secondary error byte
    localparam int E_MXF  = B_MXF - ERR_W;
    localparam int E_PGE  = 2;
    localparam int E_PE   = B_PE - ERR_W;

    typedef enum logic [1:0] {
        SEL_PRI  = 2'd0,
        SEL_SEC  = 2'd1,
        SEL_THR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              lo;
        logic              hi;
        reg_sel_e          sel;
        logic [DATA_W-1:0] val;
    } wr_req_t;

    typedef struct packed {
        logic              done;
        logic              ie;
        logic              tre;
        logic              sc_diag;
        logic [UAE_W-1:0]  uae;
        logic [ERR_W-1:0]  err;
        logic [CFG_W-1:0]  cfg;
        logic [PCHK_W-1:0] pchk;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{done: 1'b1, default: '0};

    function automatic logic is_xfer_fn(input logic [FUNC_W-1:0] f,
                                        input int unsigned lim);
        return 32'(f) >= lim;
    endfunction

    function automatic logic [DATA_W-1:0] pack_pri(input ctl_state_t s,
                                                   input logic tre_v,
                                                   input logic sc_v);
        return {sc_v, tre_v, 4'b0000, s.uae, s.done, s.ie, 6'b000000};
    endfunction

    function automatic logic [DATA_W-1:0] pack_sec(input ctl_state_t s);
        return {s.err, 2'b11, 1'b0, s.cfg};
    endfunction

    function automatic logic [DATA_W-1:0] pack_thr(input ctl_state_t s);
        return {9'b0, s.ie, 2'b00, s.pchk};
    endfunction

endpackage

// File: rtl/dkc_bus_align.sv
module dkc_bus_align
    import dkc_pkg::*;
(
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_byte,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output wr_req_t           req
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        req.sel = reg_sel_e'(wr_sel);
        req.lo  = wr_en && (!wr_byte || !wr_hi);
        req.hi  = wr_en && (!wr_byte || wr_hi);
        if (wr_byte && wr_hi)
            req.val = {wr_data[HALF-1:0], {HALF{1'b0}}};
        else if (wr_byte)
            req.val = {{HALF{1'b0}}, wr_data[HALF-1:0]};
        else
            req.val = wr_data;
    end
endmodule

// File: rtl/dkc_ctl_regs.sv
module dkc_ctl_regs
    import dkc_pkg::*;
#(
    parameter int unsigned XFER_MIN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic              drv_done,
    input  logic              drv_exc,
    input  logic              drv_attn,
    input  logic              irq_ack,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_q,
    output logic              ie_q,
    output logic              sc_lvl,
    output logic              done_rise,
    output logic              iff_set,
    output logic              ctl_clr,
    output logic              err_any,
    output logic              cmd_go,
    output logic [FUNC_W-1:0] cmd_func
);
    ctl_state_t st, st_n;

    logic pri_lo, pri_hi, sec_lo, sec_hi, thr_lo;
    logic go_bit, go_xfer, pge_hit, xfer_ok, start_ok, err_wipe, diag_set;
    logic tre_v;
    logic [FUNC_W-1:0] func_w;

    assign pri_lo = req.lo && req.sel == SEL_PRI;
    assign pri_hi = req.hi && req.sel == SEL_PRI;
    assign sec_lo = req.lo && req.sel == SEL_SEC;
    assign sec_hi = req.hi && req.sel == SEL_SEC;
    assign thr_lo = req.lo && req.sel == SEL_THR;

    assign func_w   = req.val[B_FHI:B_FLO];
    assign go_bit   = pri_lo && req.val[B_GO];
    assign go_xfer  = go_bit && is_xfer_fn(func_w, XFER_MIN);
    assign pge_hit  = go_xfer && !st.done;
    assign xfer_ok  = go_xfer && st.done;
    assign start_ok = go_bit && !pge_hit;
    assign err_wipe = ((pri_lo || pri_hi) && req.val[B_TRE]) || xfer_ok;
    assign diag_set = sec_hi &&
                      ((req.val[B_MXF] && !st.err[E_MXF]) ||
                       (req.val[B_PE]  && !st.err[E_PE]));

    assign ctl_clr   = rst || (sec_lo && req.val[B_CLR]);
    assign done_rise = (drv_done || drv_exc) && !st.done;
    assign iff_set   = pri_lo && req.val[B_DONE] && req.val[B_IE];

    always_comb begin
        st_n = st;
        // interrupt enable: acknowledge wins over writes
        if (irq_ack)
            st_n.ie = 1'b0;
        else if (pri_lo || thr_lo)
            st_n.ie = req.val[B_IE];
        // error and special-condition clearing comes before new sets
        if (err_wipe) begin
            st_n.tre     = 1'b0;
            st_n.err     = '0;
            st_n.sc_diag = 1'b0;
        end
        if (xfer_ok)
            st_n.done = 1'b0;
        if (drv_done || drv_exc)
            st_n.done = 1'b1;
        if (drv_exc)
            st_n.tre = 1'b1;
        if (pri_hi && st.done)
            st_n.uae = req.val[B_UAE +: UAE_W];
        if (sec_lo)
            st_n.cfg = req.val[CFG_W-1:0];
        if (sec_hi) begin
            st_n.err[E_MXF] = req.val[B_MXF];
            st_n.err[E_PE]  = req.val[B_PE];
        end
        if (diag_set)
            st_n.sc_diag = 1'b1;
        if (pge_hit)
            st_n.err[E_PGE] = 1'b1;
        if (thr_lo)
            st_n.pchk = req.val[PCHK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (ctl_clr) begin
            st       <= CTL_RESET;
            cmd_go   <= 1'b0;
            cmd_func <= '0;
        end else begin
            st     <= st_n;
            cmd_go <= start_ok;
            if (start_ok)
                cmd_func <= func_w;
        end
    end

    assign err_any = |st.err;
    assign tre_v   = st.tre || err_any;
    assign sc_lvl  = tre_v || st.sc_diag || drv_attn;
    assign done_q  = st.done;
    assign ie_q    = st.ie;

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_PRI: rd_data = pack_pri(st, tre_v, sc_lvl);
            SEL_SEC: rd_data = pack_sec(st);
            SEL_THR: rd_data = pack_thr(st);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dkc_irq_unit.sv
module dkc_irq_unit (
    input  logic clk,
    input  logic ctl_clr,
    input  logic irq_ack,
    input  logic iff_set,
    input  logic done_rise,
    input  logic ie_q,
    input  logic done_q,
    input  logic sc_lvl,
    output logic iff_q,
    output logic irq_req
);
    always_ff @(posedge clk) begin
        if (ctl_clr || irq_ack)
            iff_q <= 1'b0;
        else if (iff_set)
            iff_q <= 1'b1;
        else if (done_rise)
            iff_q <= ie_q;
    end

    // latched completion path OR gated level path
    assign irq_req = iff_q || (sc_lvl && done_q && ie_q);
endmodule

// File: rtl/dkc_status_irq.sv
module dkc_status_irq
    import dkc_pkg::*;
#(
    parameter int unsigned XFER_MIN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_byte,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              drv_done,
    input  logic              drv_exc,
    input  logic              drv_attn,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              cmd_go,
    output logic [FUNC_W-1:0] cmd_func
);
    wr_req_t req;
    logic done_q, ie_q, sc_lvl, done_rise, iff_set, ctl_clr, err_any, iff_q;

    dkc_bus_align u_align (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_byte (wr_byte),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .req     (req)
    );

    dkc_ctl_regs #(.XFER_MIN(XFER_MIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .drv_done  (drv_done),
        .drv_exc   (drv_exc),
        .drv_attn  (drv_attn),
        .irq_ack   (irq_ack),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .done_q    (done_q),
        .ie_q      (ie_q),
        .sc_lvl    (sc_lvl),
        .done_rise (done_rise),
        .iff_set   (iff_set),
        .ctl_clr   (ctl_clr),
        .err_any   (err_any),
        .cmd_go    (cmd_go),
        .cmd_func  (cmd_func)
    );

    dkc_irq_unit u_irq (
        .clk       (clk),
        .ctl_clr   (ctl_clr),
        .irq_ack   (irq_ack),
        .iff_set   (iff_set),
        .done_rise (done_rise),
        .ie_q      (ie_q),
        .done_q    (done_q),
        .sc_lvl    (sc_lvl),
        .iff_q     (iff_q),
        .irq_req   (irq_req)
    );
endmodule

// File: rtl/dkc_status_irq_chk.sv
module dkc_status_irq_chk #(
    parameter int unsigned XFER_MIN = 20
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        wr_byte,
    input logic        wr_hi,
    input logic [15:0] wr_data,
    input logic [1:0]  rd_sel,
    input logic [15:0] rd_data,
    input logic        drv_done,
    input logic        drv_exc,
    input logic        irq_ack,
    input logic        irq_req,
    input logic        cmd_go,
    input logic        done_q,
    input logic        ie_q,
    input logic        iff_q,
    input logic        err_any
);
    logic pri_lo_wr;
    assign pri_lo_wr = wr_en && wr_sel == 2'd0 && (!wr_byte || !wr_hi);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_req && done_q && !cmd_go)); // R1

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (pri_lo_wr && wr_data[7] && wr_data[6] && !irq_ack) |=> irq_req); // R2

    AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!done_q && (drv_done || drv_exc) && !irq_ack && !wr_en)
        |=> (iff_q == $past(ie_q))); // R3

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (!irq_req && !ie_q)); // R4

    AST_ERR_FORCE: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd0 && err_any) |-> (rd_data[15:14] == 2'b11)); // R6

    AST_PGE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (pri_lo_wr && wr_data[0] && 32'(wr_data[5:1]) >= XFER_MIN && !done_q)
        |=> !cmd_go); // R8

    AST_READY_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd1) |-> (rd_data[7:6] == 2'b11)); // R10
endmodule

bind dkc_status_irq dkc_status_irq_chk #(.XFER_MIN(XFER_MIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_byte  (wr_byte),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .drv_done (drv_done),
    .drv_exc  (drv_exc),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .cmd_go   (cmd_go),
    .done_q   (done_q),
    .ie_q     (ie_q),
    .iff_q    (iff_q),
    .err_any  (err_any)
);

// File: tb/dkc_status_irq_test.sv
`timescale 1ns/1ps
module dkc_status_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic        wr_byte = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        drv_done = 1'b0;
    logic        drv_exc = 1'b0;
    logic        drv_attn = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic        cmd_go;
    logic [4:0]  cmd_func;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dkc_status_irq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_byte(wr_byte), .wr_hi(wr_hi), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .drv_done(drv_done),
        .drv_exc(drv_exc), .drv_attn(drv_attn), .irq_ack(irq_ack),
        .irq_req(irq_req), .cmd_go(cmd_go), .cmd_func(cmd_func)
    );

    // {wsel, byte, hi, wdata, rsel, expected}
    localparam int NVEC = 14;
    localparam logic [37:0] VEC [0:NVEC-1] = '{
        {2'd1, 1'b0, 1'b0, 16'h0005, 2'd1, 16'h00C5}, // word write, unit bits
        {2'd1, 1'b1, 1'b0, 16'h000A, 2'd1, 16'h00CA}, // R13 low byte
        {2'd2, 1'b0, 1'b0, 16'h0007, 2'd2, 16'h0007}, // R14 parity bits
        {2'd2, 1'b1, 1'b1, 16'h00FF, 2'd2, 16'h0007}, // R13 third high byte ignored
        {2'd0, 1'b1, 1'b1, 16'h0003, 2'd0, 16'h0380}, // R11 ext bits while DONE
        {2'd0, 1'b1, 1'b0, 16'h0040, 2'd2, 16'h0047}, // R14 enable mirror
        {2'd2, 1'b0, 1'b0, 16'h0000, 2'd0, 16'h0380}, // R14 third clears enable
        {2'd1, 1'b1, 1'b1, 16'h0020, 2'd1, 16'h20CA}, // R12 parity error set
        {2'd3, 1'b0, 1'b0, 16'hFFFF, 2'd0, 16'hC380}, // R6 forced error bits
        {2'd0, 1'b0, 1'b0, 16'h4300, 2'd0, 16'h0380}, // R7 error clear
        {2'd3, 1'b0, 1'b0, 16'h0000, 2'd1, 16'h00CA}, // R7 secondary clean
        {2'd1, 1'b1, 1'b1, 16'h0002, 2'd0, 16'hC380}, // R12 missed transfer
        {2'd0, 1'b1, 1'b1, 16'h0040, 2'd1, 16'h00CA}, // R7 R13 clear via high byte
        {2'd3, 1'b0, 1'b0, 16'h0000, 2'd0, 16'h0080}  // R13 ext bits replaced
    };

    task automatic do_wr(input logic [1:0] s, input logic b, input logic h,
                         input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_byte = b; wr_hi = h; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_byte = 1'b0; wr_hi = 1'b0;
        #1;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: drv_done = 1'b1;
            1: drv_exc  = 1'b1;
            default: irq_ack = 1'b1;
        endcase
        @(negedge clk);
        drv_done = 1'b0; drv_exc = 1'b0; irq_ack = 1'b0;
        #1;
    endtask

    task automatic chk_reg(input logic [1:0] s, input logic [15:0] exp,
                           input string tag);
        rd_sel = s;
        #0.5;
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: reg %0d got %h expected %h", tag, s, rd_data, exp);
        end
    endtask

    task automatic chk_sig(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            do_wr(VEC[i][37:36], VEC[i][35], VEC[i][34], VEC[i][33:18]);
            chk_reg(VEC[i][17:16], VEC[i][15:0], $sformatf("table step %0d", i));
        end

        do_reset();
        // R1 reset state
        chk_reg(2'd0, 16'h0080, "R1 primary");
        chk_reg(2'd1, 16'h00C0, "R1 secondary");
        chk_reg(2'd2, 16'h0000, "R1 third");
        chk_sig(irq_req, 1'b0, "R1 irq_req");
        chk_sig(cmd_go, 1'b0, "R1 cmd_go");

        // R5 level path gated by enable
        drv_attn = 1'b1;
        do_wr(2'd0, 1'b1, 1'b0, 16'h0040);
        chk_sig(irq_req, 1'b1, "R5 attention with enable");
        chk_reg(2'd0, 16'h80C0, "R6 attention forces special condition");
        do_wr(2'd0, 1'b1, 1'b0, 16'h0000);
        chk_sig(irq_req, 1'b0, "R5 enable cleared drops level request");
        drv_attn = 1'b0;

        // R2 write DONE+IE, R4 acknowledge
        do_wr(2'd0, 1'b1, 1'b0, 16'h00C0);
        chk_sig(irq_req, 1'b1, "R2 write arms flop");
        pulse(2);
        chk_sig(irq_req, 1'b0, "R4 ack clears request");
        chk_reg(2'd0, 16'h0080, "R4 primary enable cleared");
        chk_reg(2'd2, 16'h0000, "R4 third enable cleared");

        // R9 transfer start, R3 edge with enable, R5 latched survives
        do_wr(2'd0, 1'b0, 1'b0, 16'h0069);
        chk_sig(cmd_go, 1'b1, "R9 transfer strobe");
        n_run++;
        if (cmd_func !== 5'd20) begin
            n_fail++;
            $display("FAIL R9 cmd_func: got %0d expected 20", cmd_func);
        end
        chk_reg(2'd0, 16'h0040, "R9 start clears DONE");
        chk_sig(irq_req, 1'b0, "R9 no request while busy");
        pulse(0);
        chk_sig(irq_req, 1'b1, "R3 done edge with enable");
        do_wr(2'd0, 1'b1, 1'b0, 16'h0000);
        chk_sig(irq_req, 1'b1, "R5 latched request survives enable clear");
        pulse(2);
        chk_sig(irq_req, 1'b0, "R4 ack clears latched request");

        // R3 edge without enable
        do_wr(2'd0, 1'b0, 1'b0, 16'h0029);
        chk_reg(2'd0, 16'h0000, "R9 second start");
        pulse(0);
        chk_sig(irq_req, 1'b0, "R3 done edge without enable");
        do_wr(2'd0, 1'b1, 1'b0, 16'h0040);
        chk_sig(irq_req, 1'b0, "R3 late enable does not raise");

        // R9 non-transfer GO keeps DONE
        do_wr(2'd0, 1'b0, 1'b0, 16'h0043);
        chk_sig(cmd_go, 1'b1, "R9 control command strobe");
        chk_reg(2'd0, 16'h00C0, "R9 control command keeps DONE");

        // R8 program error
        do_wr(2'd0, 1'b0, 1'b0, 16'h0029);
        chk_reg(2'd0, 16'h0000, "R9 start before error case");
        do_wr(2'd0, 1'b0, 1'b0, 16'h0029);
        chk_sig(cmd_go, 1'b0, "R8 no strobe while busy");
        chk_reg(2'd1, 16'h04C0, "R8 program error bit");
        chk_reg(2'd0, 16'hC000, "R6 program error forces bits");

        // R11 extension bits locked while busy
        do_wr(2'd0, 1'b1, 1'b1, 16'h0003);
        chk_reg(2'd0, 16'hC000, "R11 ext bits held while busy");

        // R7 error clear
        do_wr(2'd0, 1'b0, 1'b0, 16'h4000);
        chk_reg(2'd1, 16'h00C0, "R7 secondary errors cleared");
        chk_reg(2'd0, 16'h0000, "R7 transfer error cleared");

        // R6 exception alone
        pulse(1);
        chk_reg(2'd0, 16'hC080, "R6 exception sets error and DONE");
        chk_reg(2'd1, 16'h00C0, "R6 no secondary error");

        // R14 third write sets enable, R5 level request
        do_wr(2'd2, 1'b0, 1'b0, 16'h0045);
        chk_reg(2'd0, 16'hC0C0, "R14 enable through third");
        chk_sig(irq_req, 1'b1, "R5 special condition request");

        // R10 controller clear
        do_wr(2'd1, 1'b1, 1'b0, 16'h0020);
        chk_reg(2'd0, 16'h0080, "R10 primary after clear");
        chk_reg(2'd1, 16'h00C0, "R10 secondary after clear");
        chk_reg(2'd2, 16'h0000, "R10 third after clear");
        chk_sig(irq_req, 1'b0, "R10 request dropped by clear");

        // R13 high byte only
        do_wr(2'd1, 1'b1, 1'b0, 16'h0003);
        do_wr(2'd1, 1'b1, 1'b1, 16'h0020);
        chk_reg(2'd1, 16'h20C3, "R13 high byte keeps low byte");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule